// File: doc/BRIEF.md
# One-Time Program Memory Access Port

This block is the device-side port through which an external programmer fills and reads back a one-time program memory of 16-bit words. No address is ever presented on pins. The port keeps its own word address and a 2-bit clock phase, and both advance only on pulses of a programming clock pin. A 4-bit mode bus picks one of four modes: address clear, write, verify and inhibit. Bytes move over an 8-bit data path that is split into an input, an output and an output-enable, so that the surrounding pad logic can build the tristate bus. In this model the memory is a behavioural array that starts fully erased (all ones). A write can only clear bits.

The full product has 8192 words (0000h to 1FFFh). The array depth is a parameter, and the default configuration keeps it small. The address counter has one bit more than the array index, so addresses past the last word can be reached and exercised. The mode bus and the programming clock are both sampled on the system clock. A programming-clock edge is seen two system cycles after it reaches the pin.

Each word takes four programming-clock pulses. The phase counts falling edges modulo 4. Phases 0 and 1 carry the low byte and phase 2 carries the high byte. The falling edge that ends the third pulse moves the address to the next word. Phase 3 is a turnaround slot in which the bus is released.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the address and phase are 0, the output enable is low, and every array word reads FFFFh.
- R2: The mode bus md_i (bit 0 is the first mode line) decodes as 4'b0101 = address clear, 4'b1110 = write, 4'b1100 = verify, 4'b1111 = inhibit. Every other value acts as inhibit.
- R3: Outside address-clear mode, each falling edge of pclk_i advances the phase modulo 4. The falling edge that leaves phase 2 adds one to the address. Inhibit and illegal patterns advance the counters the same way.
- R4: While address-clear mode is selected, the address and phase are held at 0 and pclk_i pulses have no effect on them.
- R5: In verify mode data_oe_o is high in phases 0 to 2. data_o carries bits 7:0 of the current word in phases 0 and 1 and bits 15:8 in phase 2. data_oe_o is low in phase 3.
- R6: data_oe_o is low in write, inhibit, address-clear and illegal modes.
- R7: In write mode, each rising edge of pclk_i programs data_i into the current word. It goes to bits 7:0 in phases 0 and 1 and to bits 15:8 in phase 2. A rising edge in phase 3 writes nothing.
- R8: Programming stores the AND of the old byte and data_i, so a bit that is 0 never returns to 1.
- R9: Writes to addresses at or past the array depth are ignored, and verify reads at those addresses return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pclk_i | input | 1 | Programming clock pin |
| md_i | input | 4 | Mode select lines |
| data_i | input | 8 | Byte from the data pad |
| data_o | output | 8 | Byte driven to the data pad |
| data_oe_o | output | 1 | Data pad output enable |

## Verification
The hardest conditions to reach from the ports are the ones that depend on the address counter alone. These are an address past the last word, a rising edge in the phase-3 turnaround slot, and the hand-off between inhibit, illegal patterns and verify in the middle of a word. The only way to get there is to count out pulses. The stimulus programs every word and then keeps pulsing past the end. It writes zeros in each phase-3 slot, which would corrupt the next word if the slot were not ignored. It then reads the whole range back, including the words past the end. Separate passes move the phase in inhibit and illegal modes and then switch to verify in mid-word.

// File: rtl/otp_port_pkg.sv
package otp_port_pkg;
  typedef enum logic [1:0] {
    MODE_INHIBIT = 2'd0,
    MODE_CLEAR   = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_VERIFY  = 2'd3
  } otp_mode_e;

  localparam logic [3:0] MD_CLEAR  = 4'b0101;
  localparam logic [3:0] MD_WRITE  = 4'b1110;
  localparam logic [3:0] MD_VERIFY = 4'b1100;

  function automatic otp_mode_e decode_md(input logic [3:0] md);
    case (md)
      MD_CLEAR:  return MODE_CLEAR;
      MD_WRITE:  return MODE_WRITE;
      MD_VERIFY: return MODE_VERIFY;
      default:   return MODE_INHIBIT;
    endcase
  endfunction
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [3:0] md_i,
  output otp_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_INHIBIT;
    else         mode_o <= decode_md(md_i);
  end
endmodule

// File: rtl/otp_pclk_seq.sv
module otp_pclk_seq
  import otp_port_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  otp_mode_e     mode_i,
  output logic          rise_o,
  output logic          fall_o,
  output logic [1:0]    phase_o,
  output logic [CW-1:0] addr_o
);
  logic pclk_s1, pclk_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_s1 <= 1'b0;
      pclk_s2 <= 1'b0;
    end else begin
      pclk_s1 <= pclk_i;
      pclk_s2 <= pclk_s1;
    end
  end

  assign rise_o = pclk_s1 & ~pclk_s2;
  assign fall_o = ~pclk_s1 & pclk_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      addr_o  <= '0;
    end else if (mode_i == MODE_CLEAR) begin
      phase_o <= '0;
      addr_o  <= '0;
    end else if (fall_o) begin
      phase_o <= phase_o + 2'd1;
      // third pulse ends the word
      if (phase_o == 2'd2) addr_o <= addr_o + 1'b1;
    end
  end

  a_r4_clear_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CLEAR) |=> (addr_o == '0 && phase_o == 2'd0));

  a_r3_phase_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && mode_i != MODE_CLEAR) |=> (phase_o == $past(phase_o) + 2'd1));

  a_r3_addr_only_after_third: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_CLEAR && !(fall_o && phase_o == 2'd2)) |=> $stable(addr_o));
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int WORDS = 256,
  parameter int CW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] addr_i,
  input  logic          we_i,
  input  logic          hi_lane_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int IW = $clog2(WORDS);

  logic [15:0]   mem [WORDS];
  logic [IW-1:0] idx;
  logic          in_range;
  logic [15:0]   cur_word;

  assign idx      = addr_i[IW-1:0];
  assign in_range = ({1'b0, addr_i} < (CW+1)'(WORDS));
  assign cur_word = in_range ? mem[idx] : 16'hFFFF;
  assign rdata_o  = hi_lane_i ? cur_word[15:8] : cur_word[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (we_i && in_range) begin
      // one-time cells: bits only clear
      if (hi_lane_i) mem[idx][15:8] <= mem[idx][15:8] & wdata_i;
      else           mem[idx][7:0]  <= mem[idx][7:0]  & wdata_i;
    end
  end

  a_r8_no_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_range) |=> (((cur_word & ~$past(cur_word)) == 16'h0) || !$stable(addr_i)));

  a_r9_past_end_erased: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> (rdata_o == 8'hFF));
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_port_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pclk_i,
  input  logic [3:0] md_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o
);
  localparam int IW = $clog2(WORDS);
  localparam int CW = IW + 1;

  otp_mode_e     mode;
  logic          rise, fall;
  logic [1:0]    phase;
  logic [CW-1:0] addr;
  logic          hi_lane, we;
  logic [7:0]    rdata;

  otp_mode_dec u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .md_i   (md_i),
    .mode_o (mode)
  );

  otp_pclk_seq #(.CW(CW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pclk_i  (pclk_i),
    .mode_i  (mode),
    .rise_o  (rise),
    .fall_o  (fall),
    .phase_o (phase),
    .addr_o  (addr)
  );

  assign hi_lane = (phase == 2'd2);
  assign we      = rise && (mode == MODE_WRITE) && (phase != 2'd3);

  otp_cell_array #(.WORDS(WORDS), .CW(CW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .we_i      (we),
    .hi_lane_i (hi_lane),
    .wdata_i   (data_i),
    .rdata_o   (rdata)
  );

  assign data_oe_o = (mode == MODE_VERIFY) && (phase != 2'd3);
  assign data_o    = data_oe_o ? rdata : 8'h00;

  a_r5_release_after_third: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && phase == 2'd2 && mode != MODE_CLEAR) |=> !data_oe_o);

  a_r6_no_drive_while_writing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> !data_oe_o);
endmodule

// File: tb/otp_prog_port_bench.sv
module otp_prog_port_bench;
  localparam int WORDS = 256;
  localparam int AMOD  = 2 * WORDS;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pclk = 1'b0;
  logic [3:0] md = 4'b1111;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       oe;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] exp_mem [WORDS];
  int exp_addr  = 0;
  int exp_phase = 0;
  int exp_mode  = 0; // 0 inhibit, 1 clear, 2 write, 3 verify

  always #2 clk = ~clk;

  otp_prog_port #(.WORDS(WORDS)) u_otp_prog_port (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pclk_i    (pclk),
    .md_i      (md),
    .data_i    (din),
    .data_o    (dout),
    .data_oe_o (oe)
  );

  function automatic int mode_of(input logic [3:0] m);
    case (m)
      4'b0101: return 1;
      4'b1110: return 2;
      4'b1100: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] lo_pat(input int a);
    return ~a[7:0];
  endfunction

  function automatic logic [7:0] hi_pat(input int a);
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    md = m;
    exp_mode = mode_of(m);
    if (exp_mode == 1) begin
      exp_addr = 0;
      exp_phase = 0;
    end
    settle();
  endtask

  task automatic pulse(input logic [7:0] d);
    din = d;
    pclk = 1'b1;
    settle();
    if (exp_mode == 2 && exp_phase != 3 && exp_addr < WORDS) begin
      if (exp_phase == 2) exp_mem[exp_addr][15:8] = exp_mem[exp_addr][15:8] & d;
      else                exp_mem[exp_addr][7:0]  = exp_mem[exp_addr][7:0]  & d;
    end
    pclk = 1'b0;
    settle();
    if (exp_mode != 1) begin
      if (exp_phase == 2) exp_addr = (exp_addr + 1) % AMOD;
      exp_phase = (exp_phase + 1) % 4;
    end
  endtask

  task automatic check(input string req);
    logic       e_oe;
    logic [7:0] e_d;
    e_oe = (exp_mode == 3) && (exp_phase != 3);
    if (exp_addr >= WORDS) e_d = 8'hFF;
    else if (exp_phase == 2) e_d = exp_mem[exp_addr][15:8];
    else e_d = exp_mem[exp_addr][7:0];
    n_vec++;
    if (oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s addr=%0d phase=%0d oe actual=%b expected=%b", req, exp_addr, exp_phase, oe, e_oe);
    end else if (e_oe && dout !== e_d) begin
      n_bad++;
      $display("FAIL %s addr=%0d phase=%0d data actual=%h expected=%h", req, exp_addr, exp_phase, dout, e_d);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) exp_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    settle();

    // R1: reset state, bus released, erased array at address 0
    check("R1");
    set_mode(4'b1100);
    check("R1");
    pulse(8'h00); pulse(8'h00);
    check("R1");

    // R2 / R6: every mode pattern, output enable only for verify
    set_mode(4'b0101);
    for (int m = 0; m < 16; m++) begin
      set_mode(4'(m));
      check(m == 12 ? "R2" : "R6");
    end

    // R7 / R9: program every word and run past the end; phase 3 gets zeros
    set_mode(4'b0101);
    set_mode(4'b1110);
    for (int a = 0; a < WORDS + 4; a++) begin
      pulse(lo_pat(a));
      check("R6");
      pulse(lo_pat(a));
      pulse(hi_pat(a));
      pulse(8'h00);
    end

    // R5 / R9: read the whole range back, bus data ignored in verify
    set_mode(4'b0101);
    set_mode(4'b1100);
    for (int a = 0; a < WORDS + 4; a++) begin
      for (int p = 0; p < 4; p++) begin
        check(a >= WORDS ? "R9" : "R5");
        pulse(8'hA5);
      end
    end

    // R8: reprogramming ANDs into the existing contents
    set_mode(4'b0101);
    set_mode(4'b1110);
    pulse(8'h0F); pulse(8'hF3); pulse(8'hFF); pulse(8'h00);
    pulse(8'hF0); pulse(8'hFF); pulse(8'h81); pulse(8'h00);
    set_mode(4'b0101);
    set_mode(4'b1100);
    for (int p = 0; p < 8; p++) begin
      check("R8");
      pulse(8'h00);
    end

    // R4: pulses in address-clear mode do not move the counters
    set_mode(4'b0101);
    for (int k = 0; k < 5; k++) pulse(8'h00);
    set_mode(4'b1100);
    check("R4");

    // R3: inhibit and illegal patterns still count, write nothing
    set_mode(4'b0101);
    set_mode(4'b1111);
    for (int k = 0; k < 6; k++) pulse(8'h00);
    check("R3");
    set_mode(4'b0000);
    for (int k = 0; k < 3; k++) pulse(8'h00);
    check("R3");
    set_mode(4'b1100);
    for (int p = 0; p < 8; p++) begin
      check("R3");
      pulse(8'h00);
    end

    // R7: write mode entered mid-word lands on the high byte only
    set_mode(4'b0101);
    set_mode(4'b1111);
    pulse(8'h00); pulse(8'h00);
    set_mode(4'b1110);
    pulse(8'h0C);
    set_mode(4'b0101);
    set_mode(4'b1100);
    for (int p = 0; p < 4; p++) begin
      check("R7");
      pulse(8'h00);
    end

    summary();
  end
endmodule